// File: doc/BRIEF.md
# Configuration-Memory Test Access Port

This block is the test access port of a small in-system programmable configuration memory. It takes the serial test clock, mode select and data input, and drives a serial data output together with its output enable. Inside are the sixteen-state port controller, an 8-bit instruction register and an opcode decoder. The decoder routes the serial path through a one-bit bypass stage, through a 32-bit identification or user-code register, or out to an external boundary-scan chain.

The value captured into the instruction register is not constant. Two of its bits report, at capture time, whether the device is in programming mode and whether its read-protection is set. A device-specific instruction makes the block pull an active-low configuration-start pin low for a fixed number of test-clock cycles. That pin tells an attached FPGA to begin loading its configuration. The decoder also drives the pin-control signals for the external-test, clamp and float-all instructions.

Reset follows the house convention. `trst_n` is active low and sampled on the rising test-clock edge. Holding the mode select high for five rising edges reaches the same reset state.

Top module: `jtag_cfg_tap`

## Requirements
- R1: The controller follows the standard sixteen-state graph on rising `tck`. Five consecutive rising edges with `tms` high, or one rising edge with `trst_n` low, put it in Test-Logic-Reset.
- R2: On Capture-IR the 8-bit instruction shift register loads bits 7:5 = 000, bit 4 = `isp_mode`, bit 3 = `sec_on`, bit 2 = 0, bits 1:0 = 01. It then shifts this value out least significant bit first while the new opcode shifts in from `tdi`.
- R3: The active instruction changes only on the falling `tck` edge in Update-IR. In Test-Logic-Reset it becomes the identification opcode 8'hFE, or the bypass opcode 8'hFF when `HAS_IDCODE` is 0.
- R4: Opcode 8'hFE selects a 32-bit identification register that is captured on Capture-DR and shifted out least significant bit first. Its value is {version[3:0], 8'h50, product[7:0], 11'h049, 1'b1}, which is 32'h05006093 by default.
- R5: Opcode 8'hFD selects the same 32-bit path, loaded on Capture-DR from `user_code`.
- R6: Opcode 8'hFF selects the one-bit bypass stage, and so does every opcode not listed in R4 to R9. The bypass stage captures 0, so the first bit out is 0 and each later bit is `tdi` delayed by one shift.
- R7: Opcodes 8'h01 (sample) and 8'h00 (external test) route `bs_so` to `tdo` and assert `bs_capture`, `bs_shift` and `bs_update` in Capture-DR, Shift-DR and Update-DR. Opcodes 8'h00 and 8'hFA (clamp) assert `pin_test_drive`, and 8'hFA selects bypass.
- R8: Opcode 8'hFC asserts `pin_hiz`, which floats all device outputs, and selects bypass.
- R9: While opcode 8'hEE is active, each entry into Run-Test/Idle drives `cf_n` low for exactly `CF_PULSE_LEN` rising `tck` edges. This opcode selects bypass.
- R10: `tdo` and `tdo_oe` change only on falling `tck` edges. `tdo_oe` is high exactly while the controller is in Shift-DR or Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low reset, sampled on rising tck |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| tdo_oe | output | 1 | Enable for the tdo pad driver |
| isp_mode | input | 1 | Device is in programming mode |
| sec_on | input | 1 | Read protection is set |
| user_code | input | 32 | Value captured by the user-code instruction |
| bs_so | input | 1 | Serial output of the external boundary-scan chain |
| bs_capture | output | 1 | Boundary chain capture strobe |
| bs_shift | output | 1 | Boundary chain shift enable |
| bs_update | output | 1 | Boundary chain update strobe |
| pin_test_drive | output | 1 | Device pins are driven from the boundary chain |
| pin_hiz | output | 1 | All device outputs floated |
| cf_n | output | 1 | Active-low configuration-start pulse |

## Verification
Properties check on every cycle:
- the five-ones return to reset;
- the live capture pattern with both status bits;
- the reset instruction held in Test-Logic-Reset;
- serial entry into the 32-bit register;
- the zero captured by bypass;
- that the configuration pulse starts only in Run-Test/Idle;
- that the output enable tracks the two shift states.

Only the bench scenarios show:
- full 32-bit shift-out values for each opcode;
- the complete decode of every opcode, including an undefined one;
- the exact length of the configuration pulse;
- that `tdo` holds its value across a rising edge and moves on the falling one.

// File: rtl/jtag_cfg_tap_pkg.sv
// Shared types and constants of the configuration-memory test access port.
// Assumes a fixed 8-bit instruction and 32-bit code register layout.
package jtag_cfg_tap_pkg;

    localparam int IR_W   = 8;
    localparam int CODE_W = 32;

    // Controller states of the sixteen-state graph.
    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SHIFT_DR, ST_EXIT1_DR, ST_PAUSE_DR, ST_EXIT2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SHIFT_IR, ST_EXIT1_IR, ST_PAUSE_IR, ST_EXIT2_IR, ST_UPD_IR
    } tap_state_e;

    // Data path selection.
    typedef enum logic [1:0] {
        DR_BYPASS, DR_IDENT, DR_USER, DR_CHAIN
    } dr_sel_e;

    localparam logic [IR_W-1:0] OP_EXTEST   = 8'h00;
    localparam logic [IR_W-1:0] OP_SAMPLE   = 8'h01;
    localparam logic [IR_W-1:0] OP_CLAMP    = 8'hFA;
    localparam logic [IR_W-1:0] OP_HIGHZ    = 8'hFC;
    localparam logic [IR_W-1:0] OP_USERCODE = 8'hFD;
    localparam logic [IR_W-1:0] OP_IDCODE   = 8'hFE;
    localparam logic [IR_W-1:0] OP_BYPASS   = 8'hFF;
    localparam logic [IR_W-1:0] OP_CONFIG   = 8'hEE;

    localparam logic [7:0]  ID_FAMILY  = 8'h50;
    localparam logic [10:0] ID_COMPANY = 11'h049;

endpackage

// File: rtl/jtag_cfg_tap_fsm.sv
// Sixteen-state test-port controller.
// Advances on rising tck from tms; synchronous active-low reset to ST_RESET.
// Exposes both the current and the next state so neighbours can detect entries.
module jtag_cfg_tap_fsm
    import jtag_cfg_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state,
    output tap_state_e nxt
);

    // Next-state graph.
    always_comb begin
        case (state)
            ST_RESET:    nxt = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     nxt = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_DR:   nxt = tms ? ST_SEL_IR   : ST_CAP_DR;
            ST_CAP_DR:   nxt = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_SHIFT_DR: nxt = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_EXIT1_DR: nxt = tms ? ST_UPD_DR   : ST_PAUSE_DR;
            ST_PAUSE_DR: nxt = tms ? ST_EXIT2_DR : ST_PAUSE_DR;
            ST_EXIT2_DR: nxt = tms ? ST_UPD_DR   : ST_SHIFT_DR;
            ST_UPD_DR:   nxt = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_IR:   nxt = tms ? ST_RESET    : ST_CAP_IR;
            ST_CAP_IR:   nxt = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_SHIFT_IR: nxt = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_EXIT1_IR: nxt = tms ? ST_UPD_IR   : ST_PAUSE_IR;
            ST_PAUSE_IR: nxt = tms ? ST_EXIT2_IR : ST_PAUSE_IR;
            ST_EXIT2_IR: nxt = tms ? ST_UPD_IR   : ST_SHIFT_IR;
            ST_UPD_IR:   nxt = tms ? ST_SEL_DR   : ST_IDLE;
            default:     nxt = ST_RESET;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= nxt;
    end

    // R1: five rising edges with tms high always end in reset.
    p_five_ones_reset_r1: assert property (@(posedge tck) disable iff (!trst_n)
        (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |=> state == ST_RESET);

endmodule

// File: rtl/jtag_cfg_tap_ir.sv
// Instruction register: shift stage plus the active instruction latch.
// The shift stage captures live status bits and moves on rising tck.
// The active latch moves on falling tck in Update-IR or Test-Logic-Reset.
module jtag_cfg_tap_ir
    import jtag_cfg_tap_pkg::*;
#(
    parameter logic [IR_W-1:0] RESET_OP = OP_IDCODE
)(
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_e      state,
    input  logic            tdi,
    input  logic            isp_mode,
    input  logic            sec_on,
    output logic            ir_so,
    output logic [IR_W-1:0] ir_act
);

    logic [IR_W-1:0] ir_sr;
    logic [IR_W-1:0] cap_val;

    // Capture pattern with the live status fields.
    assign cap_val = {3'b000, isp_mode, sec_on, 1'b0, 2'b01};
    assign ir_so   = ir_sr[0];

    // Shift stage: capture, then shift least significant bit first.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            ir_sr <= '0;
        end else begin
            case (state)
                ST_CAP_IR:   ir_sr <= cap_val;
                ST_SHIFT_IR: ir_sr <= {tdi, ir_sr[IR_W-1:1]};
                default:     ir_sr <= ir_sr;
            endcase
        end
    end

    // Active instruction: loaded on the falling edge.
    always_ff @(negedge tck) begin
        if (!trst_n || state == ST_RESET) ir_act <= RESET_OP;
        else if (state == ST_UPD_IR)      ir_act <= ir_sr;
    end

    // R2: capture loads the status-bearing pattern.
    p_capture_pattern_r2: assert property (@(posedge tck) disable iff (!trst_n)
        state == ST_CAP_IR |=>
        ir_sr == {3'b000, $past(isp_mode), $past(sec_on), 3'b001});

    // R3: while in reset the reset opcode is active.
    p_reset_opcode_r3: assert property (@(posedge tck) disable iff (!trst_n)
        state == ST_RESET |-> ir_act == RESET_OP);

endmodule

// File: rtl/jtag_cfg_tap_decode.sv
// Opcode decoder: picks the data path and drives the pin-control flags.
// Purely combinational from the active instruction.
module jtag_cfg_tap_decode
    import jtag_cfg_tap_pkg::*;
(
    input  logic [IR_W-1:0] ir_act,
    output dr_sel_e         dr_sel,
    output logic            test_drive,
    output logic            hiz,
    output logic            cfg_sel
);

    // Decode table; any unknown code falls through to bypass.
    always_comb begin
        dr_sel     = DR_BYPASS;
        test_drive = 1'b0;
        hiz        = 1'b0;
        cfg_sel    = 1'b0;
        case (ir_act)
            OP_SAMPLE:   dr_sel = DR_CHAIN;
            OP_EXTEST: begin
                dr_sel     = DR_CHAIN;
                test_drive = 1'b1;
            end
            OP_CLAMP:    test_drive = 1'b1;
            OP_HIGHZ:    hiz = 1'b1;
            OP_IDCODE:   dr_sel = DR_IDENT;
            OP_USERCODE: dr_sel = DR_USER;
            OP_CONFIG:   cfg_sel = 1'b1;
            default:     dr_sel = DR_BYPASS;
        endcase
    end

endmodule

// File: rtl/jtag_cfg_tap_dr.sv
// Internal data registers: the one-bit bypass stage and a shared 32-bit
// code register that holds either the identification or the user code.
// Assumes the external chain shifts itself; only its serial output enters here.
module jtag_cfg_tap_dr
    import jtag_cfg_tap_pkg::*;
#(
    parameter logic [CODE_W-1:0] ID_VALUE = 32'h0500_6093
)(
    input  logic              tck,
    input  logic              trst_n,
    input  tap_state_e        state,
    input  dr_sel_e           dr_sel,
    input  logic              tdi,
    input  logic [CODE_W-1:0] user_code,
    input  logic              bs_so,
    output logic              dr_so
);

    logic              byp_q;
    logic [CODE_W-1:0] code_sr;
    logic              code_path;

    assign code_path = (dr_sel == DR_IDENT) || (dr_sel == DR_USER);

    // Bypass stage: captures 0, shifts tdi.
    always_ff @(posedge tck) begin
        if (!trst_n)                   byp_q <= 1'b0;
        else if (state == ST_CAP_DR)   byp_q <= 1'b0;
        else if (state == ST_SHIFT_DR) byp_q <= tdi;
    end

    // Shared code register: loads the selected code, shifts it out LSB first.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            code_sr <= '0;
        end else if (code_path) begin
            if (state == ST_CAP_DR)
                code_sr <= (dr_sel == DR_USER) ? user_code : ID_VALUE;
            else if (state == ST_SHIFT_DR)
                code_sr <= {tdi, code_sr[CODE_W-1:1]};
        end
    end

    // Serial output select.
    always_comb begin
        case (dr_sel)
            DR_IDENT, DR_USER: dr_so = code_sr[0];
            DR_CHAIN:          dr_so = bs_so;
            default:           dr_so = byp_q;
        endcase
    end

    // R4: in a code-path shift the top bit takes the previous tdi.
    p_code_shift_in_r4: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_SHIFT_DR && code_path) |=> code_sr[CODE_W-1] == $past(tdi));

    // R6: the bypass stage holds 0 after capture.
    p_bypass_zero_r6: assert property (@(posedge tck) disable iff (!trst_n)
        state == ST_CAP_DR |=> byp_q == 1'b0);

endmodule

// File: rtl/jtag_cfg_tap_cfgpulse.sv
// Configuration-start pulse generator.
// Loads a down-counter each time the controller enters Run-Test/Idle with the
// configuration opcode active; the pin is low while the counter is non-zero.
module jtag_cfg_tap_cfgpulse
    import jtag_cfg_tap_pkg::*;
#(
    parameter int PULSE_LEN = 8
)(
    input  logic       tck,
    input  logic       trst_n,
    input  tap_state_e state,
    input  tap_state_e nxt,
    input  logic       cfg_sel,
    output logic       cf_n
);

    localparam int CNT_W = $clog2(PULSE_LEN + 1);
    localparam logic [CNT_W-1:0] LEN_V = CNT_W'(PULSE_LEN);

    logic [CNT_W-1:0] cnt;
    logic             idle_entry;

    assign idle_entry = cfg_sel && (state != ST_IDLE) && (nxt == ST_IDLE);
    assign cf_n       = (cnt == '0);

    // Pulse counter: reload on entry, count down to zero.
    always_ff @(posedge tck) begin
        if (!trst_n)         cnt <= '0;
        else if (idle_entry) cnt <= LEN_V;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    // R9: a pulse begins only as the controller arrives in Run-Test/Idle.
    p_cf_starts_idle_r9: assert property (@(posedge tck) disable iff (!trst_n)
        $fell(cf_n) |-> state == ST_IDLE);

endmodule

// File: rtl/jtag_cfg_tap.sv
// Test access port top for a configuration memory.
// Combines controller, instruction register, decoder, data registers and the
// configuration pulse; retimes tdo and its enable onto falling tck.
// Assumes the boundary-scan cells sit outside and take tdi directly.
module jtag_cfg_tap
    import jtag_cfg_tap_pkg::*;
#(
    parameter bit          HAS_IDCODE   = 1'b1,
    parameter logic [3:0]  ID_VERSION   = 4'h0,
    parameter logic [7:0]  ID_PRODUCT   = 8'h06,
    parameter int          CF_PULSE_LEN = 8
)(
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    output logic              tdo_oe,
    input  logic              isp_mode,
    input  logic              sec_on,
    input  logic [CODE_W-1:0] user_code,
    input  logic              bs_so,
    output logic              bs_capture,
    output logic              bs_shift,
    output logic              bs_update,
    output logic              pin_test_drive,
    output logic              pin_hiz,
    output logic              cf_n
);

    localparam logic [CODE_W-1:0] ID_VALUE = {ID_VERSION, ID_FAMILY, ID_PRODUCT, ID_COMPANY, 1'b1};
    localparam logic [IR_W-1:0]   RESET_OP = HAS_IDCODE ? OP_IDCODE : OP_BYPASS;

    tap_state_e      state, nxt;
    logic            ir_so, dr_so, cfg_sel, in_shift;
    logic [IR_W-1:0] ir_act;
    dr_sel_e         dr_sel;

    jtag_cfg_tap_fsm u_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(state), .nxt(nxt)
    );

    jtag_cfg_tap_ir #(.RESET_OP(RESET_OP)) u_ir (
        .tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
        .isp_mode(isp_mode), .sec_on(sec_on), .ir_so(ir_so), .ir_act(ir_act)
    );

    jtag_cfg_tap_decode u_dec (
        .ir_act(ir_act), .dr_sel(dr_sel), .test_drive(pin_test_drive),
        .hiz(pin_hiz), .cfg_sel(cfg_sel)
    );

    jtag_cfg_tap_dr #(.ID_VALUE(ID_VALUE)) u_dr (
        .tck(tck), .trst_n(trst_n), .state(state), .dr_sel(dr_sel), .tdi(tdi),
        .user_code(user_code), .bs_so(bs_so), .dr_so(dr_so)
    );

    jtag_cfg_tap_cfgpulse #(.PULSE_LEN(CF_PULSE_LEN)) u_cfg (
        .tck(tck), .trst_n(trst_n), .state(state), .nxt(nxt),
        .cfg_sel(cfg_sel), .cf_n(cf_n)
    );

    // Boundary chain strobes while the chain is the selected path.
    assign bs_capture = (state == ST_CAP_DR)   && (dr_sel == DR_CHAIN);
    assign bs_shift   = (state == ST_SHIFT_DR) && (dr_sel == DR_CHAIN);
    assign bs_update  = (state == ST_UPD_DR)   && (dr_sel == DR_CHAIN);

    assign in_shift = (state == ST_SHIFT_DR) || (state == ST_SHIFT_IR);

    // Output retiming onto the falling edge.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= (state == ST_SHIFT_IR) ? ir_so : dr_so;
            tdo_oe <= in_shift;
        end
    end

    // R10: the enable is on throughout both shift states.
    p_oe_in_shift_r10: assert property (@(posedge tck) disable iff (!trst_n)
        in_shift |-> tdo_oe);

    // R10: the enable is off in every other state.
    p_oe_off_elsewhere_r10: assert property (@(posedge tck) disable iff (!trst_n)
        !in_shift |-> !tdo_oe);

endmodule

// File: tb/jtag_cfg_tap_tb.sv
// Self-checking bench: an opcode table walked by one loop, then directed tests.
module jtag_cfg_tap_tb;

    localparam int          PULSE = 8;
    localparam logic [31:0] IDV   = 32'h0500_6093;
    localparam logic [31:0] DIN   = 32'hC3A5_0F96;

    // Row layout: {opcode[7:0], test_drive, hiz, path[1:0]}
    // with path 0 = bypass, 1 = identification, 2 = user code, 3 = chain.
    localparam logic [11:0] VEC [0:8] = '{
        {8'hFF, 1'b0, 1'b0, 2'd0},   // R6 bypass
        {8'h01, 1'b0, 1'b0, 2'd3},   // R7 sample
        {8'h00, 1'b1, 1'b0, 2'd3},   // R7 external test
        {8'hFA, 1'b1, 1'b0, 2'd0},   // R7 clamp
        {8'hFC, 1'b0, 1'b1, 2'd0},   // R8 float all
        {8'hFE, 1'b0, 1'b0, 2'd1},   // R4 identification
        {8'hFD, 1'b0, 1'b0, 2'd2},   // R5 user code
        {8'hEE, 1'b0, 1'b0, 2'd0},   // R9 configuration start
        {8'h5A, 1'b0, 1'b0, 2'd0}    // R6 undefined code
    };

    logic        tck = 1'b0;
    logic        trst_n, tms, tdi, isp_mode, sec_on, bs_so;
    logic [31:0] user_code;
    logic        tdo, tdo_oe, bs_capture, bs_shift, bs_update;
    logic        pin_test_drive, pin_hiz, cf_n;

    int checks = 0;
    int fails  = 0;
    int oe_bad = 0;

    always #5 tck = ~tck;

    jtag_cfg_tap #(.CF_PULSE_LEN(PULSE)) u_dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
        .isp_mode(isp_mode), .sec_on(sec_on), .user_code(user_code), .bs_so(bs_so),
        .bs_capture(bs_capture), .bs_shift(bs_shift), .bs_update(bs_update),
        .pin_test_drive(pin_test_drive), .pin_hiz(pin_hiz), .cf_n(cf_n)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // One tck period: drive, pass rising then falling edge, settle.
    task automatic tick(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    task automatic shift_bits(input int n, input logic [31:0] din,
                              output logic [31:0] dout, output int nbs);
        dout = '0;
        nbs  = 0;
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            if (bs_shift) nbs++;
            if (!tdo_oe) oe_bad++;
            tick(i == n - 1, din[i]);
        end
    endtask

    // From Run-Test/Idle: load an opcode, return to Run-Test/Idle.
    task automatic load_ir(input logic [7:0] op, output logic [7:0] cap);
        logic [31:0] o;
        int nb;
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        shift_bits(8, {24'h0, op}, o, nb);
        cap = o[7:0];
        tick(1, 0); tick(0, 0);
    endtask

    // From Run-Test/Idle: a 32-bit data scan, return to Run-Test/Idle.
    task automatic scan_dr(input logic [31:0] din, output logic [31:0] dout, output int nbs);
        tick(1, 0); tick(0, 0); tick(0, 0);
        shift_bits(32, din, dout, nbs);
        tick(1, 0); tick(0, 0);
    endtask

    function automatic string tag_of(input logic [7:0] op);
        case (op)
            8'h01, 8'h00, 8'hFA: return "R7";
            8'hFC:               return "R8";
            8'hFE:               return "R4";
            8'hFD:               return "R5";
            8'hEE:               return "R9";
            default:             return "R6";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge tck);
        fails++;
        $display("FAIL watchdog act=timeout exp=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0]  cap;
        logic [31:0] dout, exp;
        int          nbs, low;

        trst_n = 1'b0; tms = 1'b1; tdi = 1'b0;
        isp_mode = 1'b1; sec_on = 1'b1; bs_so = 1'b1;
        user_code = 32'h1234_ABCD;
        repeat (3) @(negedge tck);
        #1;

        // Reset state (R1, R3, R10).
        chk("R10", "oe in reset", 32'(tdo_oe), 32'd0);
        chk("R9", "cf_n in reset", 32'(cf_n), 32'd1);
        chk("R3", "no pin control at reset", {30'd0, pin_test_drive, pin_hiz}, 32'd0);
        trst_n = 1'b1;
        tick(0, 0);
        chk("R10", "oe idle", 32'(tdo_oe), 32'd0);
        scan_dr(DIN, dout, nbs);
        chk("R3", "reset instruction is identification", dout, IDV);

        // Table walk over every opcode.
        for (int v = 0; v < 9; v++) begin
            logic [7:0] op;
            op = VEC[v][11:4];
            load_ir(op, cap);
            chk("R2", "capture pattern status 1/1", 32'(cap), 32'h19);
            chk(tag_of(op), "pin_test_drive", 32'(pin_test_drive), 32'(VEC[v][3]));
            chk(tag_of(op), "pin_hiz", 32'(pin_hiz), 32'(VEC[v][2]));
            if (op == 8'hEE) chk("R9", "cf_n low after load", 32'(cf_n), 32'd0);
            scan_dr(DIN, dout, nbs);
            case (VEC[v][1:0])
                2'd1:    exp = IDV;
                2'd2:    exp = user_code;
                2'd3:    exp = 32'hFFFF_FFFF;
                default: exp = {DIN[30:0], 1'b0};
            endcase
            chk(tag_of(op), "data scan out", dout, exp);
            chk(tag_of(op), "chain shift cycles", 32'(nbs), (VEC[v][1:0] == 2'd3) ? 32'd32 : 32'd0);
        end
        chk("R10", "oe low inside shifts", 32'(oe_bad), 32'd0);

        // R2: capture pattern follows both status inputs.
        isp_mode = 1'b0; sec_on = 1'b0;
        load_ir(8'hFF, cap);
        chk("R2", "capture pattern status 0/0", 32'(cap), 32'h01);
        isp_mode = 1'b1;
        load_ir(8'hFF, cap);
        chk("R2", "capture pattern status 1/0", 32'(cap), 32'h11);

        // R9: exact pulse length, no retrigger while idling.
        load_ir(8'hEE, cap);
        low = (cf_n == 1'b0) ? 1 : 0;
        for (int k = 0; k < 20; k++) begin
            tick(0, 0);
            if (cf_n == 1'b0) low++;
        end
        chk("R9", "pulse length", 32'(low), 32'(PULSE));

        // R1: five tms-high cycles from Shift-DR restore the reset instruction.
        load_ir(8'h00, cap);
        chk("R7", "external test drives pins", 32'(pin_test_drive), 32'd1);
        tick(1, 0); tick(0, 0); tick(0, 0);
        repeat (5) tick(1, 0);
        chk("R1", "five ones clear test drive", 32'(pin_test_drive), 32'd0);
        tick(0, 0);
        scan_dr(DIN, dout, nbs);
        chk("R1", "identification after five ones", dout, IDV);

        // R1: synchronous trst_n reset.
        load_ir(8'hFD, cap);
        trst_n = 1'b0;
        tick(0, 0);
        trst_n = 1'b1;
        tick(0, 0);
        scan_dr(DIN, dout, nbs);
        chk("R1", "identification after trst_n", dout, IDV);

        // R10: tdo moves on the falling edge only.
        user_code = 32'h5555_5555;
        load_ir(8'hFD, cap);
        tick(1, 0); tick(0, 0); tick(0, 0);
        chk("R10", "first user bit", 32'(tdo), 32'd1);
        tms = 1'b0; tdi = 1'b0;
        @(posedge tck); #1;
        chk("R10", "tdo held past rising edge", 32'(tdo), 32'd1);
        @(negedge tck); #1;
        chk("R10", "tdo updated at falling edge", 32'(tdo), 32'd0);
        repeat (5) tick(1, 0);
        tick(0, 0);
        chk("R10", "oe off after shift", 32'(tdo_oe), 32'd0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule